// File: doc/BRIEF.md
# UART Hardware Flow-Control Unit

This unit handles request-to-send / clear-to-send handshaking for a UART without software involvement. On the transmit side, it holds back the start of a new character until the remote side shows it is ready. The remote side signals readiness by pulling the active-low clear-to-send input low. That input is first passed through a flop synchronizer. A character that is already being shifted out is never cut short. The unit only decides whether the next character may begin.

On the receive side, the unit compares the receive FIFO fill level with a programmable trigger threshold. It drives the active-low request-to-send output from that comparison. The output goes high when the level reaches the threshold and low again once reads bring the level back under it. The threshold is held one entry below the FIFO capacity. This guarantees room for the one byte the remote side may still send after request-to-send drops. A byte that arrives while the FIFO is already full raises a one-cycle overflow pulse.

Two control bits select the mode:

| Enable bit | RTS bit | Mode | Request-to-send | Clear-to-send |
|---|---|---|---|---|
| 1 | 1 | Full automatic | Automated from the FIFO level | Gates transmit starts |
| 1 | 0 | Clear-to-send-only | Software controlled | Gates transmit starts |
| 0 | any | Off | Software controlled | Ignored |

Whenever request-to-send is software controlled, its output is the inverse of the RTS bit.

Top module: `uart_autoflow`

## Requirements
- R1: With `afc_en_i`=0, `rts_n_o` equals the inverse of `rts_bit_i` one clock after it is sampled, and `tx_start_ok_o` does not depend on `cts_n_i`.
- R2: With `afc_en_i`=1 and `rts_bit_i`=1 (full mode), `rts_n_o` is 1 one clock after `rx_level_i` is at or above the effective threshold, and 0 one clock after it is below.
- R3: With `afc_en_i`=1 and `rts_bit_i`=0 (clear-to-send-only mode), `rts_n_o` is held at 1 whatever the FIFO level is.
- R4: The effective threshold is `rx_thresh_i` clamped to the range 1 to DEPTH-1. A threshold of 0 acts as 1, and any value of DEPTH or more acts as DEPTH-1.
- R5: `tx_start_ok_o` is 1 only when `tx_req_i`=1 and `tx_busy_i`=0, and, when autoflow is enabled, the synchronized clear-to-send is low. A busy transmitter therefore always finishes its current character.
- R6: A change on `cts_n_i` reaches `tx_start_ok_o` after exactly two rising clock edges and not earlier.
- R7: A byte pushed (`rx_push_i`=1) at level DEPTH-1 raises no overflow, which leaves room for the one extra byte after request-to-send drops.
- R8: `ovf_o` is 1 for one cycle after each clock edge at which `rx_push_i`=1 and `rx_level_i` >= DEPTH, and is 0 otherwise.
- R9: During reset, `rts_n_o`=1 and `ovf_o`=0, and the synchronized clear-to-send reads as high, so no transmit start is permitted in autoflow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| afc_en_i | input | 1 | Autoflow enable control bit |
| rts_bit_i | input | 1 | RTS control bit; selects full mode when autoflow is on, otherwise drives the request-to-send line |
| cts_n_i | input | 1 | Active-low clear-to-send from the remote side (asynchronous) |
| rts_n_o | output | 1 | Active-low request-to-send to the remote side |
| rx_level_i | input | LVL_W | Receive FIFO fill level, 0 to DEPTH |
| rx_thresh_i | input | LVL_W | Programmable receive trigger threshold |
| rx_push_i | input | 1 | A received byte is written into the FIFO this cycle |
| tx_req_i | input | 1 | Transmitter has a character ready to send |
| tx_busy_i | input | 1 | Transmitter is currently shifting a character out |
| tx_start_ok_o | output | 1 | Permit for the transmitter to start the next character |
| ovf_o | output | 1 | One-cycle pulse: a byte arrived while the FIFO was full |

## Verification
The bench builds the unit with DEPTH=8, which gives a 4-bit level and threshold. With this size, a full FIFO and the threshold limits are reached in a few directed values. Threshold inputs of 0 and 15 show both clamp directions. Levels 7 and 8 separate the allowed extra byte from a real overflow.

The two-stage synchronizer default lets the bench count the exact edge on which a clear-to-send change takes effect.

// File: rtl/afc_pkg.sv
// Package: shared mode type and decode for the autoflow unit.
// Assumes the two control bits are static or change only between characters.
package afc_pkg;

    typedef enum logic [1:0] {
        AFC_OFF      = 2'd0,
        AFC_CTS_ONLY = 2'd1,
        AFC_FULL     = 2'd2
    } afc_mode_e;

    // Map enable and RTS control bits onto an operating mode.
    function automatic afc_mode_e afc_decode(input logic en, input logic rts);
        if (!en)
            return AFC_OFF;
        else if (rts)
            return AFC_FULL;
        else
            return AFC_CTS_ONLY;
    endfunction

endpackage

// File: rtl/afc_cts_sync.sv
// Module: afc_cts_sync
// Carries the asynchronous active-low clear-to-send input into the clock
// domain through a chain of STAGES flops. All flops reset to 1 (not clear).
// Assumes STAGES >= 2.
module afc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_async,
    output logic cts_n_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= cts_n_async;
                end
            end else begin : g_next
                // Later flops shift the value down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign cts_n_sync = chain[STAGES-1];

endmodule

// File: rtl/afc_rts_ctrl.sv
// Module: afc_rts_ctrl
// Drives the registered active-low request-to-send output. In full mode it
// compares the FIFO level with the threshold clamped to [1, DEPTH-1], so one
// slot always remains free after the line drops. Otherwise it follows the
// inverse of the RTS control bit.
// Assumes level is never above DEPTH.
module afc_rts_ctrl
    import afc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  afc_mode_e        mode,
    input  logic             rts_bit,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             rts_n
);

    localparam logic [LVL_W-1:0] TH_MIN = LVL_W'(1);
    localparam logic [LVL_W-1:0] TH_MAX = LVL_W'(DEPTH - 1);

    logic [LVL_W-1:0] eff_th;
    logic             rts_n_nxt;

    // Clamp the programmed threshold into the usable range.
    always_comb begin
        if (thresh < TH_MIN)      eff_th = TH_MIN;
        else if (thresh > TH_MAX) eff_th = TH_MAX;
        else                      eff_th = thresh;
    end

    // Pick the next line value for the active mode.
    always_comb begin
        if (mode == AFC_FULL) rts_n_nxt = (level >= eff_th);
        else                  rts_n_nxt = ~rts_bit;
    end

    // Register the line; deasserted (high) in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b1;
        else        rts_n <= rts_n_nxt;
    end

endmodule

// File: rtl/afc_tx_gate.sv
// Module: afc_tx_gate
// Grants the transmitter permission to start its next character. It never
// affects a character in progress; a busy transmitter simply gets no new
// start. Assumes cts_n_sync is already in the clock domain.
module afc_tx_gate
    import afc_pkg::*;
(
    input  afc_mode_e mode,
    input  logic      cts_n_sync,
    input  logic      tx_req,
    input  logic      tx_busy,
    output logic      start_ok
);

    logic remote_ready;

    // The remote side's readiness matters only when autoflow is on.
    always_comb remote_ready = (mode == AFC_OFF) ? 1'b1 : ~cts_n_sync;

    // A start needs a pending character, an idle shifter and a ready peer.
    always_comb start_ok = tx_req & ~tx_busy & remote_ready;

endmodule

// File: rtl/afc_ovf_det.sv
// Module: afc_ovf_det
// Flags, one cycle later, a receive push that hits an already full FIFO.
// Assumes the level input is the count before this cycle's push.
module afc_ovf_det #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] level,
    output logic             ovf
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // Register a single-cycle overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= push && (level >= FULL_LVL);
    end

endmodule

// File: rtl/uart_autoflow.sv
// Module: uart_autoflow (top)
// Automatic request-to-send / clear-to-send control for a UART. It decodes
// the mode from two control bits, synchronizes clear-to-send, gates
// transmit starts, drives request-to-send from the FIFO level and flags
// overflow. Assumes rx_level_i counts entries 0..DEPTH before this cycle's push.
module uart_autoflow
    import afc_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             afc_en_i,
    input  logic             rts_bit_i,
    input  logic             cts_n_i,
    output logic             rts_n_o,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_thresh_i,
    input  logic             rx_push_i,
    input  logic             tx_req_i,
    input  logic             tx_busy_i,
    output logic             tx_start_ok_o,
    output logic             ovf_o
);

    afc_mode_e mode;
    logic      cts_n_sync;

    // Decode the operating mode from the control bits.
    always_comb mode = afc_decode(afc_en_i, rts_bit_i);

    afc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_n_async (cts_n_i),
        .cts_n_sync  (cts_n_sync)
    );

    afc_tx_gate u_gate (
        .mode       (mode),
        .cts_n_sync (cts_n_sync),
        .tx_req     (tx_req_i),
        .tx_busy    (tx_busy_i),
        .start_ok   (tx_start_ok_o)
    );

    afc_rts_ctrl #(.DEPTH(DEPTH)) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .rts_bit (rts_bit_i),
        .level   (rx_level_i),
        .thresh  (rx_thresh_i),
        .rts_n   (rts_n_o)
    );

    afc_ovf_det #(.DEPTH(DEPTH)) u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push_i),
        .level (rx_level_i),
        .ovf   (ovf_o)
    );

endmodule

// File: rtl/uart_autoflow_chk.sv
// Module: uart_autoflow_chk
// Port-level protocol checks for uart_autoflow, attached by bind.
module uart_autoflow_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             afc_en_i,
    input logic             rts_bit_i,
    input logic             cts_n_i,
    input logic             rts_n_o,
    input logic [LVL_W-1:0] rx_level_i,
    input logic [LVL_W-1:0] rx_thresh_i,
    input logic             rx_push_i,
    input logic             tx_req_i,
    input logic             tx_busy_i,
    input logic             tx_start_ok_o,
    input logic             ovf_o
);

    logic [LVL_W-1:0] th_c;

    // Independent model of the clamped threshold.
    always_comb begin
        if (rx_thresh_i == '0)                       th_c = LVL_W'(1);
        else if (rx_thresh_i > LVL_W'(DEPTH - 1))    th_c = LVL_W'(DEPTH - 1);
        else                                         th_c = rx_thresh_i;
    end

    // R1
    off_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !afc_en_i |=> (rts_n_o == !$past(rts_bit_i)));

    // R2
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en_i && rts_bit_i && rx_level_i >= th_c) |=> rts_n_o);

    // R2
    full_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en_i && rts_bit_i && rx_level_i < th_c) |=> !rts_n_o);

    // R3
    cts_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en_i && !rts_bit_i) |=> rts_n_o);

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_ok_o |-> (tx_req_i && !tx_busy_i));

    // R6
    cts_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_ok_o && afc_en_i) |-> !$past(cts_n_i, 2));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_i && rx_level_i >= LVL_W'(DEPTH)) |=> ovf_o);

    // R7
    no_false_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_push_i && rx_level_i >= LVL_W'(DEPTH)) |=> !ovf_o);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rts_n_o && !ovf_o));

endmodule

bind uart_autoflow uart_autoflow_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .afc_en_i      (afc_en_i),
    .rts_bit_i     (rts_bit_i),
    .cts_n_i       (cts_n_i),
    .rts_n_o       (rts_n_o),
    .rx_level_i    (rx_level_i),
    .rx_thresh_i   (rx_thresh_i),
    .rx_push_i     (rx_push_i),
    .tx_req_i      (tx_req_i),
    .tx_busy_i     (tx_busy_i),
    .tx_start_ok_o (tx_start_ok_o),
    .ovf_o         (ovf_o)
);

// File: tb/uart_autoflow_test.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset and timing checks.
module uart_autoflow_test;

    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int NVEC  = 15;

    typedef struct packed {
        logic             en;
        logic             rts;
        logic             ctsn;
        logic [LVL_W-1:0] lvl;
        logic [LVL_W-1:0] th;
        logic             req;
        logic             busy;
        logic             push;
        logic             x_rtsn;
        logic             x_ok;
        logic             x_ovf;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b1,1'b1,4'd5,4'd4,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R1 off, cts ignored
        '{1'b0,1'b0,1'b0,4'd0,4'd4,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R1 off, rts bit 0
        '{1'b1,1'b1,1'b0,4'd3,4'd4,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R2 below threshold
        '{1'b1,1'b1,1'b0,4'd4,4'd4,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R2 at threshold
        '{1'b1,1'b1,1'b1,4'd2,4'd4,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R5 cts high blocks
        '{1'b1,1'b1,1'b0,4'd5,4'd4,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0}, // R5 busy blocks start
        '{1'b1,1'b0,1'b0,4'd7,4'd4,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R3 cts-only, high level
        '{1'b1,1'b0,1'b1,4'd0,4'd4,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R3 cts-only, empty
        '{1'b1,1'b1,1'b0,4'd6,4'd15,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R4 clamp high, 6<7
        '{1'b1,1'b1,1'b0,4'd7,4'd15,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R4 clamp high, 7>=7
        '{1'b1,1'b1,1'b0,4'd0,4'd0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R4 clamp low, 0<1
        '{1'b1,1'b1,1'b0,4'd1,4'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R4 clamp low, 1>=1
        '{1'b1,1'b1,1'b0,4'd7,4'd4,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0}, // R7 extra byte accepted
        '{1'b1,1'b1,1'b0,4'd8,4'd4,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R8 push when full
        '{1'b0,1'b0,1'b1,4'd8,4'd4,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1}  // R8 off mode, R5 no req
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             afc_en_i, rts_bit_i, cts_n_i;
    logic             rts_n_o;
    logic [LVL_W-1:0] rx_level_i, rx_thresh_i;
    logic             rx_push_i, tx_req_i, tx_busy_i;
    logic             tx_start_ok_o, ovf_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_autoflow #(.DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .afc_en_i      (afc_en_i),
        .rts_bit_i     (rts_bit_i),
        .cts_n_i       (cts_n_i),
        .rts_n_o       (rts_n_o),
        .rx_level_i    (rx_level_i),
        .rx_thresh_i   (rx_thresh_i),
        .rx_push_i     (rx_push_i),
        .tx_req_i      (tx_req_i),
        .tx_busy_i     (tx_busy_i),
        .tx_start_ok_o (tx_start_ok_o),
        .ovf_o         (ovf_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; afc_en_i = 1'b1; rts_bit_i = 1'b1; cts_n_i = 1'b0;
        rx_level_i = '0; rx_thresh_i = 4'd4; rx_push_i = 1'b0;
        tx_req_i = 1'b1; tx_busy_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 rts_n in reset", rts_n_o, 1'b1);
        check("R9 ovf in reset", ovf_o, 1'b0);
        check("R9 no start in reset", tx_start_ok_o, 1'b0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            afc_en_i = VEC[i].en;  rts_bit_i = VEC[i].rts; cts_n_i = VEC[i].ctsn;
            rx_level_i = VEC[i].lvl; rx_thresh_i = VEC[i].th;
            tx_req_i = VEC[i].req; tx_busy_i = VEC[i].busy; rx_push_i = VEC[i].push;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("vec %0d rts_n", i), rts_n_o, VEC[i].x_rtsn);
            check($sformatf("vec %0d start_ok", i), tx_start_ok_o, VEC[i].x_ok);
            check($sformatf("vec %0d ovf", i), ovf_o, VEC[i].x_ovf);
        end

        // R6 clear-to-send takes exactly two edges
        afc_en_i = 1'b1; rts_bit_i = 1'b1; cts_n_i = 1'b1; rx_push_i = 1'b0;
        tx_req_i = 1'b1; tx_busy_i = 1'b0; rx_level_i = 4'd3; rx_thresh_i = 4'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cts_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R6 start after one edge", tx_start_ok_o, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R6 start after two edges", tx_start_ok_o, 1'b1);
        // R2 request-to-send updates one edge after the level crosses
        check("R2 rts_n below", rts_n_o, 1'b0);
        rx_level_i = 4'd4;
        #1;
        check("R2 rts_n before edge", rts_n_o, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R2 rts_n after edge", rts_n_o, 1'b1);
        rx_level_i = 4'd3;
        @(posedge clk); @(negedge clk);
        check("R2 rts_n after read", rts_n_o, 1'b0);
        // R8 overflow is a single-cycle pulse
        rx_level_i = 4'd8; rx_push_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8 ovf pulse", ovf_o, 1'b1);
        rx_push_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 ovf clears", ovf_o, 1'b0);
        // R5 busy mid-character with cts raised: no new start
        cts_n_i = 1'b1; tx_busy_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 held while busy", tx_start_ok_o, 1'b0);

        finish_run();
    end

endmodule